// File: doc/BRIEF.md
# Oversampling Serial Byte Receiver

This block takes in bytes from a raw asynchronous serial line. It conditions the line through a short flip-flop synchronizer. It then looks at the line only on a sampling tick that runs at sixteen times the bit rate. That tick comes from a plain clock divider inside the block. The divider ratio is a parameter, so the system clock must be sixteen times the bit rate times `CLK_DIV`.

A frame begins when one tick sample reads 0 and the sample on the tick before it read 1. The block waits eight ticks and then checks the start bit again at its middle. If the start bit reads 1 there, the event is treated as noise and dropped with no output. After a good start bit, each data bit is sampled sixteen ticks after the bit before it, least significant bit first. A parity bit follows the data when parity is enabled, and the stop bit comes last.

When the frame format is correct, the byte is presented with a one-cycle valid strobe. When the format is wrong, a one-cycle error strobe is raised and the byte output is left unchanged. The block has no buffering. The byte output holds its value until the next good frame arrives.

Top module: `uart_os_rx`

## Requirements
- R1: After reset, `rx_valid` and `rx_err` are 0 and `rx_byte` is 0x00. The line is treated as idle high, and one bit lasts 16*`CLK_DIV` clock cycles.
- R2: A frame starts only when a tick sample of the synchronized line reads 0 and the tick sample before it read 1. The receiver state changes only on the cycle after a sampling tick.
- R3: The start bit is sampled again 8 ticks after the falling sample. If that sample reads 1, the block returns to idle and raises neither strobe. A low pulse shorter than half a bit therefore produces no output.
- R4: Each data bit is sampled 16 ticks after the previous sample. The first data bit after the start bit lands in `rx_byte[0]`, and the eighth lands in `rx_byte[7]`.
- R5: A stop-bit sample of 1, together with a correct parity check when parity is enabled, gives `rx_valid` high for exactly one cycle. In that same cycle `rx_byte` shows the new byte. `rx_byte` changes in no other cycle.
- R6: A stop-bit sample of 0 gives `rx_err` high for exactly one cycle. `rx_valid` stays low and `rx_byte` keeps its value.
- R7: After a stop bit of 0, no new frame starts until the line has been seen at 1. A line held low after such an error produces no further strobe.
- R8: With `PARITY_EN`=1, a ninth bit follows the data. The number of ones in the data bits plus that ninth bit must be even. If it is odd, `rx_err` pulses and `rx_valid` stays low.
- R9: `rx_valid` and `rx_err` are never high in the same cycle.
- R10: Frames sent back to back, with no idle time after the stop bit, are both received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Raw asynchronous serial line, idles high |
| rx_byte | output | DATA_BITS | Last byte that arrived with a correct frame |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| rx_err | output | 1 | One-cycle strobe for a rejected frame (bad stop bit or bad parity) |

## Verification
Two functions can fall on the same tick. One is the stop-bit verdict that ends a frame. The other is the watch for the falling edge of the next start bit, which uses the stop-bit sample as its "previous 1".

The bench provokes this with zero-gap frames, so the next start edge arrives half a bit after the verdict. It passes only if both bytes arrive, in order, with exactly two valid strobes and no error strobe.

The error path meets the same edge watch when a bad stop bit is followed by a line held low. The bench judges this by the absence of any strobe until a later clean frame arrives.

// File: rtl/uart_os_rx_pkg.sv
package uart_os_rx_pkg;
  localparam int OVERSAMPLE = 16;
  localparam int HALF_BIT   = OVERSAMPLE / 2;
  localparam int TCNT_W     = $clog2(OVERSAMPLE);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/uart_os_rx_tick.sv
module uart_os_rx_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R1
endmodule

// File: rtl/uart_os_rx_sync.sv
module uart_os_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] ff;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) ff <= '1;
        else     ff <= {ff[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = ff[STAGES-1];
endmodule

// File: rtl/uart_os_rx_frame.sv
module uart_os_rx_frame
  import uart_os_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter bit PARITY_EN = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 line,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 rx_err
);
  localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [IW-1:0]     LAST_IDX = IW'(DATA_BITS - 1);
  localparam logic [TCNT_W-1:0] FULL_CNT = TCNT_W'(OVERSAMPLE - 1);
  localparam logic [TCNT_W-1:0] MID_CNT  = TCNT_W'(HALF_BIT - 1);

  rx_state_e            state;
  logic [TCNT_W-1:0]    cnt;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 par_bit;
  logic                 prev;
  logic                 par_bad;

  assign par_bad = PARITY_EN && ((^shreg) ^ par_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      par_bit  <= 1'b0;
      prev     <= 1'b1;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      if (tick) begin
        prev <= line;
        case (state)
          ST_IDLE: begin
            if (prev && !line) begin
              state <= ST_START;
              cnt   <= '0;
            end
          end
          ST_START: begin
            if (cnt == MID_CNT) begin
              cnt   <= '0;
              idx   <= '0;
              state <= line ? ST_IDLE : ST_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt == FULL_CNT) begin
              cnt   <= '0;
              shreg <= {line, shreg[DATA_BITS-1:1]};
              if (idx == LAST_IDX) state <= PARITY_EN ? ST_PAR : ST_STOP;
              else                 idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (cnt == FULL_CNT) begin
              cnt     <= '0;
              par_bit <= line;
              state   <= ST_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt == FULL_CNT) begin
              cnt <= '0;
              if (!line) begin
                rx_err <= 1'b1;
                state  <= ST_WAIT_HI;
              end else if (par_bad) begin
                rx_err <= 1'b1;
                state  <= ST_IDLE;
              end else begin
                rx_valid <= 1'b1;
                rx_byte  <= shreg;
                state    <= ST_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_WAIT_HI: begin
            if (line) state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_STATE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (state != $past(state)) |-> $past(tick)); // R2
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_WAIT_HI && state == ST_IDLE) |-> $past(line)); // R7
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R5
  AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_byte) |-> rx_valid); // R5
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_err |=> !rx_err); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && rx_err)); // R9
endmodule

// File: rtl/uart_os_rx.sv
module uart_os_rx #(
  parameter int CLK_DIV     = 4,
  parameter int DATA_BITS   = 8,
  parameter bit PARITY_EN   = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxd,
  output logic [DATA_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 rx_err
);
  logic tick;
  logic line_s;

  uart_os_rx_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  uart_os_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(line_s)
  );

  uart_os_rx_frame #(.DATA_BITS(DATA_BITS), .PARITY_EN(PARITY_EN)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .line    (line_s),
    .rx_byte (rx_byte),
    .rx_valid(rx_valid),
    .rx_err  (rx_err)
  );
endmodule

// File: tb/tb_uart_os_rx.sv
module tb_uart_os_rx;
  localparam int CLK_DIV = 4;
  localparam int BITC    = 16 * CLK_DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic rxd_p = 1'b1;
  logic [7:0] rx_byte, rx_byte_p;
  logic rx_valid, rx_err, rx_valid_p, rx_err_p;

  always #4 clk = ~clk;

  uart_os_rx #(.CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst(rst), .rxd(rxd),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err));

  uart_os_rx #(.CLK_DIV(CLK_DIV), .PARITY_EN(1'b1)) dut_par (
    .clk(clk), .rst(rst), .rxd(rxd_p),
    .rx_byte(rx_byte_p), .rx_valid(rx_valid_p), .rx_err(rx_err_p));

  int checks = 0;
  int fails  = 0;
  int vcnt = 0, ecnt = 0, vcnt_p = 0, ecnt_p = 0;
  logic [7:0] first_byte = 8'h00;
  logic [7:0] last_byte  = 8'h00;

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (vcnt == 0) first_byte = rx_byte;
        last_byte = rx_byte;
        vcnt++;
      end
      if (rx_err) ecnt++;
      if (rx_valid && rx_err) begin
        checks++; fails++;
        $display("FAIL R9: both strobes high, actual 1/1 expected not both");
      end
      if (rx_valid_p) vcnt_p++;
      if (rx_err_p)   ecnt_p++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    vcnt = 0; ecnt = 0; vcnt_p = 0; ecnt_p = 0;
  endtask

  task automatic drive_bit(input bit to_p, input logic b, input int clocks);
    @(negedge clk);
    if (to_p) rxd_p = b; else rxd = b;
    repeat (clocks - 1) @(negedge clk);
  endtask

  task automatic send(input bit to_p, input logic [7:0] d, input bit has_par,
                      input logic pb, input logic stopb);
    drive_bit(to_p, 1'b0, BITC);
    for (int i = 0; i < 8; i++) drive_bit(to_p, d[i], BITC);
    if (has_par) drive_bit(to_p, pb, BITC);
    drive_bit(to_p, stopb, BITC);
  endtask

  // {data[7:0], stop bit, expect valid, expect error}
  localparam int NVEC = 6;
  localparam logic [10:0] VEC [NVEC] = '{
    {8'h55, 1'b1, 1'b1, 1'b0},
    {8'h00, 1'b1, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b1, 1'b0},
    {8'hA3, 1'b1, 1'b1, 1'b0},
    {8'h4A, 1'b0, 1'b0, 1'b1},
    {8'h81, 1'b1, 1'b1, 1'b0}
  };

  task automatic run_all();
    logic [7:0] good;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rx_valid == 1'b0 && rx_err == 1'b0, "R1 strobes after reset", {rx_valid, rx_err}, 0);
    check(rx_byte == 8'h00, "R1 byte after reset", rx_byte, 0);
    drive_bit(1'b0, 1'b1, 2 * BITC);

    good = 8'h00;
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] d;
      d = VEC[k][10:3];
      clear_counts();
      send(1'b0, d, 1'b0, 1'b0, VEC[k][2]);
      if (!VEC[k][2]) drive_bit(1'b0, 1'b0, 3 * BITC); // R7 line stays low
      drive_bit(1'b0, 1'b1, 2 * BITC);
      if (VEC[k][1]) good = d;
      check(vcnt == int'(VEC[k][1]), "R5 valid count", vcnt, VEC[k][1]);
      check(ecnt == int'(VEC[k][0]), "R6 error count", ecnt, VEC[k][0]);
      check(rx_byte == good, "R4 byte value LSB first", rx_byte, good);
    end

    // R3 short glitch: low for 3 ticks only
    clear_counts();
    drive_bit(1'b0, 1'b0, 3 * CLK_DIV);
    drive_bit(1'b0, 1'b1, 3 * BITC);
    check(vcnt == 0 && ecnt == 0, "R3 glitch ignored", vcnt + ecnt, 0);
    check(rx_byte == good, "R3 byte untouched by glitch", rx_byte, good);

    // R7 error then line held low for a long time, then clean frame
    clear_counts();
    send(1'b0, 8'h3C, 1'b0, 1'b0, 1'b0);
    drive_bit(1'b0, 1'b0, 12 * BITC);
    check(ecnt == 1 && vcnt == 0, "R7 single error while held low", ecnt, 1);
    drive_bit(1'b0, 1'b1, 2 * BITC);
    check(vcnt == 0 && ecnt == 1, "R7 no frame on release", vcnt, 0);
    check(rx_byte == good, "R6 byte kept after error", rx_byte, good);
    clear_counts();
    send(1'b0, 8'hC5, 1'b0, 1'b0, 1'b1);
    drive_bit(1'b0, 1'b1, 2 * BITC);
    check(vcnt == 1 && rx_byte == 8'hC5, "R7 recovers after error", rx_byte, 8'hC5);

    // R10 back-to-back frames
    clear_counts();
    send(1'b0, 8'h31, 1'b0, 1'b0, 1'b1);
    send(1'b0, 8'h32, 1'b0, 1'b0, 1'b1);
    drive_bit(1'b0, 1'b1, 2 * BITC);
    check(vcnt == 2 && ecnt == 0, "R10 two strobes", vcnt, 2);
    check(first_byte == 8'h31, "R10 first byte", first_byte, 8'h31);
    check(last_byte == 8'h32, "R10 second byte", last_byte, 8'h32);

    // R8 parity variant: 0x07 has three ones, even parity bit is 1
    drive_bit(1'b1, 1'b1, 2 * BITC);
    clear_counts();
    send(1'b1, 8'h07, 1'b1, 1'b1, 1'b1);
    drive_bit(1'b1, 1'b1, 2 * BITC);
    check(vcnt_p == 1 && ecnt_p == 0 && rx_byte_p == 8'h07, "R8 good parity", rx_byte_p, 8'h07);
    clear_counts();
    send(1'b1, 8'h18, 1'b1, 1'b1, 1'b1);
    drive_bit(1'b1, 1'b1, 2 * BITC);
    check(vcnt_p == 0 && ecnt_p == 1, "R8 bad parity rejected", ecnt_p, 1);
    check(rx_byte_p == 8'h07, "R8 byte kept on parity error", rx_byte_p, 8'h07);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule